// File: doc/BRIEF.md
# UART Addressed Register Bridge

This block sits between a byte-wide UART receiver, a byte-wide UART transmitter and a simple register bus. It turns an addressed byte stream into register reads and writes. Every frame opens with a header byte that holds a direction flag and a 7-bit device number. Address bytes follow the header. A write continues with data bytes. A read continues with one byte that says how many data bytes to return. The UART has no select line, so the end of a frame is found by line silence. When no byte has arrived for a set number of bit times, the parser goes back to waiting for a header.

If the header's device number is not this block's own, the whole frame is skipped without any bus or transmit activity. A read answers with a copy of the header byte, followed by the requested register bytes taken from consecutive addresses. Each transmitted byte is held until the transmitter takes it. The register read for the following byte is started only after that.

Top module: `uart_reg_bridge`

## Requirements
- R1: Header bit 7 chooses the direction (1 = read, 0 = write), and header bits 6:0 are compared against the DEV_ID parameter.
- R2: A frame whose header bits 6:0 differ from DEV_ID causes no reg_wr, no reg_rd and no transmitted byte until the idle timeout ends it.
- R3: Exactly ADDR_BYTES address bytes follow the header, and the first one received is the most significant byte of the start address.
- R4: In a write frame, each data byte accepted produces a single-cycle reg_wr pulse. In that cycle reg_wdata is the byte and reg_addr is the current address.
- R5: In a read frame, the byte after the address is a count N. The response is the header byte unchanged, then N bytes. Each of those N bytes is the reg_rdata value present the cycle after a single-cycle reg_rd pulse.
- R6: A count of 0 returns only the header copy and issues no reg_rd.
- R7: The address rises by one after each byte written or read. The carry crosses byte boundaries, and the address wraps modulo 2^(8*ADDR_BYTES).
- R8: A frame ends after IDLE_BITS*CLKS_PER_BIT clock cycles with no accepted byte, and the next byte is then decoded as a header. Bytes spaced closer than that stay in the same frame.
- R9: tx_valid stays high with tx_data unchanged until tx_ready. reg_rd is issued only in the cycle after a byte has been accepted. rx_ready is low while a response is being sent.
- R10: After reset, tx_valid, reg_wr and reg_rd are low, rx_ready is high, and the first byte is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Bridge accepts a received byte |
| tx_valid | output | 1 | Byte waiting for the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 8*ADDR_BYTES | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
The hardest cases to reach from the ports depend on time rather than on byte values. One is a frame that must end purely from silence. The other is a response whose transmitter stalls for several cycles between bytes. The bench places byte gaps just below and well above the idle limit, and it checks through later read frames whether the stray bytes became data or a new header. During the read sweeps, tx_ready is driven from a pseudo-random sequence so that the transmitter often refuses bytes. The sweeps also start at addresses next to a byte carry and at the top of the address space, so that the increment has to cross both.

// File: rtl/ub_pkg.sv
package ub_pkg;

  typedef enum logic [3:0] {
    ST_HDR, ST_ADDR, ST_WDATA, ST_CNT, ST_SKIP, ST_RESP, ST_RDREQ, ST_RDWAIT
  } ub_state_e;

  function automatic logic hdr_is_read(input logic [7:0] h);
    return h[7];
  endfunction

  function automatic logic hdr_id_hit(input logic [7:0] h, input logic [6:0] id);
    return h[6:0] == id;
  endfunction

  function automatic logic state_listens(input ub_state_e s);
    return (s == ST_HDR) || (s == ST_ADDR) || (s == ST_WDATA) ||
           (s == ST_CNT) || (s == ST_SKIP);
  endfunction

  function automatic logic state_can_expire(input ub_state_e s);
    return (s == ST_ADDR) || (s == ST_WDATA) || (s == ST_CNT) || (s == ST_SKIP);
  endfunction

endpackage

// File: rtl/ub_idle_timer.sv
module ub_idle_timer #(
  parameter int LIMIT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (kick)                       cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))        cnt_q <= cnt_q + CW'(1);
  end

  assign expire = !kick && (cnt_q == CW'(LIMIT - 1));

  AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R8

endmodule

// File: rtl/ub_tx_hold.sv
module ub_tx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       sent
);
  assign sent = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (sent) begin
      tx_valid <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !tx_valid); // R9

endmodule

// File: rtl/ub_frame_fsm.sv
module ub_frame_fsm
  import ub_pkg::*;
#(
  parameter logic [6:0] DEV_ID     = 7'h2A,
  parameter int         ADDR_BYTES = 2,
  parameter int         ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              rx_fire,
  input  logic              expire,
  input  logic              tx_sent,
  output logic              tx_load,
  output logic [7:0]        tx_load_data,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  localparam int AW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  ub_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [AW-1:0]     abyte_q;
  logic [7:0]        remain_q;
  logic [7:0]        hdr_q;

  logic addr_step;
  logic last_abyte;
  logic end_idle;

  assign rx_ready   = state_listens(state);
  assign rx_fire    = rx_valid && rx_ready;
  assign last_abyte = (abyte_q == AW'(ADDR_BYTES - 1));
  assign end_idle   = expire && state_can_expire(state);
  assign addr_step  = ((state == ST_WDATA) && rx_fire) || (state == ST_RDWAIT);

  assign reg_wr       = (state == ST_WDATA) && rx_fire;
  assign reg_wdata    = rx_data;
  assign reg_rd       = (state == ST_RDREQ);
  assign reg_addr     = addr_q;
  assign tx_load      = ((state == ST_CNT) && rx_fire) || (state == ST_RDWAIT);
  assign tx_load_data = (state == ST_RDWAIT) ? reg_rdata : hdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HDR;
      addr_q   <= '0;
      abyte_q  <= '0;
      remain_q <= '0;
      hdr_q    <= '0;
    end else begin
      case (state)
        ST_HDR: if (rx_fire) begin
          hdr_q   <= rx_data;
          abyte_q <= '0;
          addr_q  <= '0;
          state   <= hdr_id_hit(rx_data, DEV_ID) ? ST_ADDR : ST_SKIP;
        end
        ST_ADDR: begin
          if (rx_fire) begin
            addr_q <= (addr_q << 8) | ADDR_W'(rx_data);
            if (last_abyte) state <= hdr_is_read(hdr_q) ? ST_CNT : ST_WDATA;
            else            abyte_q <= abyte_q + AW'(1);
          end else if (end_idle) begin
            state <= ST_HDR;
          end
        end
        ST_WDATA: begin
          if (rx_fire)       addr_q <= addr_q + ADDR_W'(1);
          else if (end_idle) state  <= ST_HDR;
        end
        ST_CNT: begin
          if (rx_fire) begin
            remain_q <= rx_data;
            state    <= ST_RESP;
          end else if (end_idle) begin
            state <= ST_HDR;
          end
        end
        ST_SKIP: if (end_idle) state <= ST_HDR;
        ST_RESP: if (tx_sent) state <= (remain_q == 8'd0) ? ST_HDR : ST_RDREQ;
        ST_RDREQ: state <= ST_RDWAIT;
        ST_RDWAIT: begin
          addr_q   <= addr_q + ADDR_W'(1);
          remain_q <= remain_q - 8'd1;
          state    <= ST_RESP;
        end
        default: state <= ST_HDR;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> (reg_addr == $past(reg_addr) + ADDR_W'(1))); // R7
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!reg_wr && !reg_rd && !tx_load)); // R2
  AST_IDLE_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    end_idle |=> (state == ST_HDR)); // R8
  AST_ECHO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_CNT) && rx_fire) |-> (tx_load_data == {1'b1, DEV_ID})); // R5
  AST_RD_AFTER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(tx_sent)); // R9
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RESP) && tx_sent && (remain_q == 8'd0)) |=> !reg_rd); // R6

endmodule

// File: rtl/uart_reg_bridge.sv
module uart_reg_bridge #(
  parameter logic [6:0] DEV_ID       = 7'h2A,
  parameter int         ADDR_BYTES   = 2,
  parameter int         CLKS_PER_BIT = 16,
  parameter int         IDLE_BITS    = 20,
  localparam int        ADDR_W       = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  localparam int IDLE_CYC = CLKS_PER_BIT * IDLE_BITS;

  logic       rx_fire;
  logic       idle_expire;
  logic       tx_sent;
  logic       tx_load;
  logic [7:0] tx_load_data;

  ub_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (rx_fire),
    .expire (idle_expire)
  );

  ub_frame_fsm #(
    .DEV_ID     (DEV_ID),
    .ADDR_BYTES (ADDR_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .rx_fire      (rx_fire),
    .expire       (idle_expire),
    .tx_sent      (tx_sent),
    .tx_load      (tx_load),
    .tx_load_data (tx_load_data),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata)
  );

  ub_tx_hold u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_data (tx_load_data),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .sent      (tx_sent)
  );

  AST_RX_CLOSED_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready); // R9

endmodule

// File: tb/tb_uart_reg_bridge.sv
module tb_uart_reg_bridge;
  localparam logic [6:0] ID  = 7'h2A;
  localparam int         CPB = 4;
  localparam int         IDB = 20;
  localparam int         QUIET = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_valid, tx_ready, reg_wr, reg_rd;
  logic [7:0] tx_data, reg_wdata, reg_rdata;
  logic [15:0] reg_addr;

  always #2.5 clk = ~clk;

  uart_reg_bridge #(.DEV_ID(ID), .ADDR_BYTES(2), .CLKS_PER_BIT(CPB), .IDLE_BITS(IDB)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int total = 0;
  int bad = 0;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  rd_q = '0;
  logic [15:0] wr_log [64];
  logic [7:0]  tx_log [64];
  int wr_n = 0;
  int rd_n = 0;
  int tx_n = 0;
  bit slow = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  int viol = 0;
  logic hold_prev = 1'b0;
  logic [7:0] hold_data = '0;

  assign reg_rdata = rd_q;
  assign tx_ready = 1'b0 | rdy_q;
  logic rdy_q = 1'b1;

  initial for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end

  // register responder: one-cycle read latency
  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      if (wr_n < 64) wr_log[wr_n] <= reg_addr;
      wr_n <= wr_n + 1;
    end
    if (reg_rd) begin
      rd_q <= mem[reg_addr[7:0]];
      rd_n <= rd_n + 1;
    end
  end

  // transmitter model and handshake monitor, away from the active edge
  always @(negedge clk) begin
    logic nr;
    if (hold_prev && (!tx_valid || tx_data != hold_data)) viol++;
    if (reg_rd && tx_valid) viol++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    nr = slow ? (lfsr[2:0] == 3'd0) : 1'b1;
    rdy_q = nr;
    if (tx_valid && nr) begin
      if (tx_n < 64) tx_log[tx_n] = tx_data;
      tx_n++;
    end
    hold_prev = tx_valid && !nr;
    hold_data = tx_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int i, input int n);
    return 8'((a * 7 + i * 13 + n * 3 + 5) & 255);
  endfunction

  task automatic wr_frame(input logic [6:0] id, input logic [15:0] a, input int n, input int seed);
    send_byte({1'b0, id}, 10);
    send_byte(a[15:8], 10);
    send_byte(a[7:0], 10);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      logic [15:0] ea;
      v  = pat(a, i, seed);
      ea = a + 16'(i);
      if (id == ID) exp_mem[ea[7:0]] = v;
      send_byte(v, 10);
    end
    repeat (QUIET) @(negedge clk);
  endtask

  task automatic rd_frame(input logic [6:0] id, input logic [15:0] a, input int n, input int limit);
    int w;
    tx_n = 0;
    send_byte({1'b1, id}, 10);
    send_byte(a[15:8], 10);
    send_byte(a[7:0], 10);
    send_byte(8'(n), 0);
    w = 0;
    while (tx_n < n + 1 && w < limit) begin
      @(negedge clk);
      w++;
    end
    repeat (QUIET) @(negedge clk);
  endtask

  task automatic check_read(input logic [15:0] a, input int n, input string req);
    chk(tx_n == n + 1, "R5 response length", tx_n, n + 1);
    if (tx_n > 0) chk(tx_log[0] == {1'b1, ID}, "R5 header copy", tx_log[0], {1'b1, ID});
    for (int k = 0; k < n && k + 1 < tx_n && k < 63; k++) begin
      logic [15:0] ea;
      ea = a + 16'(k);
      chk(tx_log[k + 1] == exp_mem[ea[7:0]], req, tx_log[k + 1], exp_mem[ea[7:0]]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    int r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!tx_valid, "R10 tx_valid", tx_valid, 0);
    chk(!reg_wr && !reg_rd, "R10 strobes", {reg_wr, reg_rd}, 0);
    chk(rx_ready, "R10 rx_ready", rx_ready, 1);

    // R1 R3 R4: byte order of the address and write strobes
    w0 = wr_n;
    wr_frame(ID, 16'h1234, 2, 1);
    chk(wr_n - w0 == 2, "R4 write count", wr_n - w0, 2);
    chk(wr_log[w0] == 16'h1234, "R3 address byte order", wr_log[w0], 16'h1234);
    chk(wr_log[w0 + 1] == 16'h1235, "R7 write increment", wr_log[w0 + 1], 16'h1235);
    rd_frame(ID, 16'h1234, 2, 2000);
    check_read(16'h1234, 2, "R1 R5 read data");

    // R2 foreign device: write ignored, read silent
    w0 = wr_n;
    r0 = rd_n;
    wr_frame(ID ^ 7'h01, 16'h1234, 3, 9);
    chk(wr_n == w0, "R2 no write", wr_n - w0, 0);
    rd_frame(ID ^ 7'h01, 16'h1234, 3, 300);
    chk(tx_n == 0, "R2 no transmit", tx_n, 0);
    chk(rd_n == r0, "R2 no read", rd_n - r0, 0);
    rd_frame(ID, 16'h1234, 2, 2000);
    check_read(16'h1234, 2, "R2 data kept");

    // R6 zero count
    r0 = rd_n;
    rd_frame(ID, 16'h1234, 0, 300);
    chk(tx_n == 1, "R6 only header", tx_n, 1);
    chk(tx_log[0] == {1'b1, ID}, "R6 header value", tx_log[0], {1'b1, ID});
    chk(rd_n == r0, "R6 no reg_rd", rd_n - r0, 0);

    // R8 silence ends a write frame: the late byte is a new header
    send_byte({1'b0, ID}, 10);
    send_byte(8'h00, 10);
    send_byte(8'h40, 10);
    send_byte(8'hC3, 10);
    exp_mem[8'h40] = 8'hC3;
    repeat (QUIET) @(negedge clk);
    send_byte({1'b0, ID}, 10);
    send_byte(8'h00, 10);
    send_byte(8'h50, 10);
    send_byte(8'h77, 10);
    exp_mem[8'h50] = 8'h77;
    repeat (QUIET) @(negedge clk);
    rd_frame(ID, 16'h0040, 2, 2000);
    check_read(16'h0040, 2, "R8 frame closed by silence");
    rd_frame(ID, 16'h0050, 1, 2000);
    check_read(16'h0050, 1, "R8 late byte taken as header");
    // R8 a gap below the limit keeps the frame open
    send_byte({1'b0, ID}, 10);
    send_byte(8'h00, 10);
    send_byte(8'h60, 10);
    send_byte(8'h11, 60);
    send_byte(8'h22, 10);
    exp_mem[8'h60] = 8'h11;
    exp_mem[8'h61] = 8'h22;
    repeat (QUIET) @(negedge clk);
    rd_frame(ID, 16'h0060, 2, 2000);
    check_read(16'h0060, 2, "R8 short gap stays in frame");

    // R7 R9 sweep: carries, wrap, stalled transmitter
    foreach (wr_log[i]) wr_log[i] = '0;
    for (int s = 0; s < 3; s++) begin
      logic [15:0] a;
      a = (s == 0) ? 16'h00FE : (s == 1) ? 16'h01FD : 16'hFFFE;
      for (int n = 1; n <= 6; n++) begin
        w0 = wr_n;
        wr_frame(ID, a, n, n + s);
        for (int i = 0; i < n; i++)
          chk(wr_log[w0 + i] == a + 16'(i), "R7 write address", wr_log[w0 + i], a + 16'(i));
        slow = (n % 2) == 1;
        r0 = rd_n;
        rd_frame(ID, a, n, 4000);
        slow = 1'b0;
        chk(rd_n - r0 == n, "R5 reg_rd count", rd_n - r0, n);
        check_read(a, n, "R7 R9 read data");
        if (wr_n > 48) wr_n = 0;
      end
    end
    chk(viol == 0, "R9 hold and read order", viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule